// File: doc/BRIEF.md
# Polarity-Selectable Phase Comparator

This block compares a reference pulse train against a divided-down oscillator pulse train, both sampled on a system clock. It reports which train is ahead through a three-state pump control pin, modelled as a value plus an enable. It also drives a push-pull "raise" output and an open-drain "pull" output for an external charge pump, a lock flag and a monitor output. A slope-select input swaps the sense of every correction output, so a loop can use an oscillator whose frequency rises or falls with tuning voltage.

The core is a three-state machine that mirrors a two-flip-flop phase-frequency detector. The states are `PH_EQUAL` (neither flop set), `PH_REF_LEADS` (reference flop set) and `PH_DIV_LEADS` (divider flop set). There are five named transitions:

- `T_REF_FIRST`: from `PH_EQUAL` to `PH_REF_LEADS`, on a reference rise alone.
- `T_DIV_FIRST`: from `PH_EQUAL` to `PH_DIV_LEADS`, on a divider rise alone.
- `T_DIV_CATCH`: from `PH_REF_LEADS` to `PH_EQUAL`, on any divider rise.
- `T_REF_CATCH`: from `PH_DIV_LEADS` to `PH_EQUAL`, on any reference rise.
- `T_HOLD`: every other case, including both rises together in `PH_EQUAL` and a repeat rise of the input that already leads.

Because a repeat rise of the leading input is absorbed, the detectable phase error spans plus or minus one full cycle.

Top module: `polarity_phase_comparator`

## Requirements
- R1: After reset the outputs are as follows: the state is `PH_EQUAL`, `pump_en`=0, `pump_drive`=0, `ext_raise`=0, `ext_pull_en`=0, `lock_ok`=1 and `monitor`=0. The slope select is taken as 1 until the first clock after reset.
- R2: Only a 0-to-1 change of `ref_pulse` or `div_pulse` between two consecutive clock samples counts as an edge. A level that is held high has no effect on the state.
- R3: In `PH_EQUAL`, a reference edge alone moves the state to `PH_REF_LEADS`, and a divider edge alone moves it to `PH_DIV_LEADS`. Outputs reflect the new state after the same clock edge that samples the input edge.
- R4: In a leading state, an edge of the other input returns the state to `PH_EQUAL`, even if the leading input also rises in that cycle. A further edge of the leading input keeps the state. Edges of both inputs in the same cycle in `PH_EQUAL` keep `PH_EQUAL`.
- R5: With the registered slope select at 1, the outputs are as follows. In `PH_REF_LEADS`: `pump_en`=1, `pump_drive`=1, `ext_raise`=0, `ext_pull_en`=1. In `PH_DIV_LEADS`: `pump_en`=1, `pump_drive`=0, `ext_raise`=1, `ext_pull_en`=0.
- R6: With the registered slope select at 0, the outputs are as follows. In `PH_REF_LEADS`: `pump_en`=1, `pump_drive`=0, `ext_raise`=1, `ext_pull_en`=0. In `PH_DIV_LEADS`: `pump_en`=1, `pump_drive`=1, `ext_raise`=0, `ext_pull_en`=1.
- R7: In `PH_EQUAL`, for either slope, `pump_en`=0, `pump_drive`=0, `ext_raise`=0 and `ext_pull_en`=0. The pull output has no drive-high encoding: it is either pulling low or released.
- R8: `lock_ok` is 1 exactly when the state is `PH_EQUAL`, and 0 while either input leads.
- R9: `monitor` equals the registered `ref_pulse` sample when the registered slope select is 1, and the registered `div_pulse` sample when it is 0. Both samples are taken at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | Reference divider pulse train |
| div_pulse | input | 1 | Feedback divider pulse train |
| slope_sel | input | 1 | 1 = positive tuning slope, 0 = negative |
| pump_drive | output | 1 | Pump control level when enabled (0 when released) |
| pump_en | output | 1 | Pump control drive enable (0 = high impedance) |
| ext_raise | output | 1 | Push-pull correction output for an external pump |
| ext_pull_en | output | 1 | Open-drain output, 1 = pulling low |
| lock_ok | output | 1 | 1 while no phase difference is held |
| monitor | output | 1 | Selected divider sample for observation |

## Verification
Two functions can fall in the same cycle: a reference rise and a divider rise together, and a slope change together with a state change. The bench provokes both by sweeping every three-cycle sequence of the three inputs without resetting between sequences. This also reaches coincident rises while a state is leading. A model in the bench derives the state from the edge rules alone and decodes the outputs from the two polarity tables. Each cycle is judged by comparing the full output vector against that expectation.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        PH_EQUAL     = 2'b00,
        PH_REF_LEADS = 2'b01,
        PH_DIV_LEADS = 2'b10
    } phase_state_t;

    localparam int LANE_REF   = 0;
    localparam int LANE_DIV   = 1;
    localparam int LANE_SLOPE = 2;
    localparam int NUM_LANES  = 3;
endpackage

// File: rtl/pfd_edge_sampler.sv
module pfd_edge_sampler #(
    parameter int               LANES   = 3,
    parameter logic [LANES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] rise
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[g] <= RST_VAL[g];
            else        q[g] <= raw[g];
        end
        assign rise[g] = raw[g] & ~q[g];
    end
endmodule

// File: rtl/pfd_state_core.sv
module pfd_state_core
    import pfd_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_rise,
    input  logic         div_rise,
    output phase_state_t state
);
    phase_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_EQUAL;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PH_EQUAL: begin
                if (ref_rise && !div_rise)      nxt = PH_REF_LEADS; // T_REF_FIRST
                else if (div_rise && !ref_rise) nxt = PH_DIV_LEADS; // T_DIV_FIRST
            end
            PH_REF_LEADS: if (div_rise) nxt = PH_EQUAL;             // T_DIV_CATCH
            PH_DIV_LEADS: if (ref_rise) nxt = PH_EQUAL;             // T_REF_CATCH
            default:      nxt = PH_EQUAL;
        endcase
    end
endmodule

// File: rtl/pfd_out_encoder.sv
module pfd_out_encoder
    import pfd_pkg::*;
(
    input  phase_state_t state,
    input  logic         slope_pos,
    input  logic         ref_q,
    input  logic         div_q,
    output logic         pump_drive,
    output logic         pump_en,
    output logic         ext_raise,
    output logic         ext_pull_en,
    output logic         lock_ok,
    output logic         monitor
);
    logic ahead, behind, push_up, push_dn;

    always_comb begin
        ahead   = (state == PH_REF_LEADS);
        behind  = (state == PH_DIV_LEADS);
        push_up = slope_pos ? ahead  : behind;
        push_dn = slope_pos ? behind : ahead;
        pump_en     = push_up | push_dn;
        pump_drive  = push_up;
        ext_raise   = push_dn;
        ext_pull_en = push_up;
        lock_ok     = (state == PH_EQUAL);
        monitor     = slope_pos ? ref_q : div_q;
    end
endmodule

// File: rtl/polarity_phase_comparator.sv
module polarity_phase_comparator
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic div_pulse,
    input  logic slope_sel,
    output logic pump_drive,
    output logic pump_en,
    output logic ext_raise,
    output logic ext_pull_en,
    output logic lock_ok,
    output logic monitor
);
    localparam logic [NUM_LANES-1:0] LANE_RST = NUM_LANES'(1) << LANE_SLOPE;

    logic [NUM_LANES-1:0] raw_in, smp_q, smp_rise;
    phase_state_t         state;

    assign raw_in = {slope_sel, div_pulse, ref_pulse};

    pfd_edge_sampler #(.LANES(NUM_LANES), .RST_VAL(LANE_RST)) u_sampler (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_in),
        .q    (smp_q),
        .rise (smp_rise)
    );

    pfd_state_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_rise(smp_rise[LANE_REF]),
        .div_rise(smp_rise[LANE_DIV]),
        .state   (state)
    );

    pfd_out_encoder u_enc (
        .state      (state),
        .slope_pos  (smp_q[LANE_SLOPE]),
        .ref_q      (smp_q[LANE_REF]),
        .div_q      (smp_q[LANE_DIV]),
        .pump_drive (pump_drive),
        .pump_en    (pump_en),
        .ext_raise  (ext_raise),
        .ext_pull_en(ext_pull_en),
        .lock_ok    (lock_ok),
        .monitor    (monitor)
    );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
    input logic clk,
    input logic rst_n,
    input logic pump_drive,
    input logic pump_en,
    input logic ext_raise,
    input logic ext_pull_en,
    input logic lock_ok
);
    // R8
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ok |-> (!pump_en && !ext_raise && !ext_pull_en));

    // R8
    lead_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_en || ext_raise || ext_pull_en) |-> !lock_ok);

    // R5
    drive_high_pairs_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_en && pump_drive) |-> (ext_pull_en && !ext_raise));

    // R6
    drive_low_pairs_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_en && !pump_drive) |-> (ext_raise && !ext_pull_en));

    // R7
    released_is_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_en |-> !pump_drive);
endmodule

bind polarity_phase_comparator pfd_checker u_pfd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pump_drive (pump_drive),
    .pump_en    (pump_en),
    .ext_raise  (ext_raise),
    .ext_pull_en(ext_pull_en),
    .lock_ok    (lock_ok)
);

// File: tb/test_polarity_phase_comparator.sv
`timescale 1ns/1ps
module test_polarity_phase_comparator;
    logic clk = 0, rst_n = 0;
    logic ref_pulse = 0, div_pulse = 0, slope_sel = 1;
    logic pump_drive, pump_en, ext_raise, ext_pull_en, lock_ok, monitor;
    int   checks = 0, errors = 0;
    bit   done = 0;

    int m_st = 0;
    bit m_pr = 0, m_pd = 0, m_pol = 1;

    always #5 clk = ~clk;

    polarity_phase_comparator i_polarity_phase_comparator (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
        .slope_sel(slope_sel), .pump_drive(pump_drive), .pump_en(pump_en),
        .ext_raise(ext_raise), .ext_pull_en(ext_pull_en), .lock_ok(lock_ok),
        .monitor(monitor)
    );

    task automatic expect_outs(string tag, int st, bit pol, bit mon);
        bit lead, lag, up, dn;
        logic [5:0] exp_v, act_v;
        lead = (st == 1);
        lag  = (st == 2);
        up   = pol ? lead : lag;
        dn   = pol ? lag : lead;
        exp_v = {up | dn, up, dn, up, st == 0, mon};
        act_v = {pump_en, pump_drive, ext_raise, ext_pull_en, lock_ok, monitor};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s t=%0t act{en,drv,raise,pull,lock,mon}=%b exp=%b",
                     tag, $time, act_v, exp_v);
        end
    endtask

    // drive one input vector, advance the bench model, check after the edge
    task automatic step(bit r, bit d, bit f, string tag);
        bit rr, dr;
        @(negedge clk);
        ref_pulse = r; div_pulse = d; slope_sel = f;
        rr = r & ~m_pr;
        dr = d & ~m_pd;
        case (m_st)
            0: if (rr && !dr) m_st = 1; else if (dr && !rr) m_st = 2;
            1: if (dr) m_st = 0;
            2: if (rr) m_st = 0;
            default: m_st = 0;
        endcase
        m_pr = r; m_pd = d; m_pol = f;
        @(posedge clk);
        #2;
        expect_outs(tag, m_st, m_pol, m_pol ? m_pr : m_pd);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #2;
        expect_outs("R1 reset", 0, 1, 0);
        @(negedge clk) rst_n = 1;
        #1;
        expect_outs("R1 after release", 0, 1, 0);

        step(1, 0, 1, "R3 ref first, R5");
        step(1, 0, 1, "R2 held level");
        step(0, 0, 1, "R2 fall");
        step(1, 0, 1, "R4 repeat leading edge");
        step(0, 1, 1, "R4 catch, R8");
        step(0, 0, 1, "R7 equal");
        step(0, 1, 1, "R3 div first, R5");
        step(1, 1, 1, "R4 ref catch with div held");
        step(0, 0, 0, "R9 slope low");
        step(1, 1, 0, "R4 coincident in equal");
        step(0, 0, 0, "R7 equal slope low");
        step(1, 0, 0, "R6 ref leads slope low");
        step(0, 0, 0, "R6 hold");
        step(0, 1, 0, "R4 catch slope low");
        step(0, 0, 0, "R6 idle");
        step(0, 1, 0, "R6 div leads slope low");
        step(1, 1, 1, "R4 catch with slope change");

        for (int s = 0; s < 512; s++) begin
            for (int k = 0; k < 3; k++) begin
                int v;
                v = (s >> (3 * k)) & 7;
                step(v[0], v[1], v[2], "R4 R5 R6 R9 sweep");
            end
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule